// File: doc/BRIEF.md
# Multi-Supply Power-On Reset Sequencer

This block turns a set of per-supply "above trip level" flags into one master reset for a device's configuration logic. Each supply flag, and each I/O level-shifter check flag, comes from an analog detector outside the block. It is treated as an asynchronous digital input and is synchronized by two flops. The master reset is asserted (`por_n_o` low) from power-up and stays asserted while the supplies ramp. It is released only after the last supply has crossed its trip level, a selectable fast or standard delay has elapsed, and every level-shifter check has passed.

A ramp-time watchdog measures the window from the first supply detected high to the last one. If that window exceeds the limit, the block enters a failure state. In that state the I/Os stay tri-stated and reset stays asserted until every supply has gone low again. If any supply drops below trip while the device is running, reset re-asserts in the same cycle that the synchronized drop is seen. A one-cycle strobe tells the configuration controller that it may start. All timing values are parameters counted in cycles of a free-running clock. The defaults assume 50 MHz, where the 10 ms ramp limit is 500,000 cycles.

The block has no data stream, so all its pins are plain control and status pins with no valid/ready handshake.

Top module: `por_seq`

## Requirements
- R1: Every supply and level-shifter flag passes through two flops. A change on an input pin can reach `por_n_o` no earlier than after the second rising clock edge following it.
- R2: After `rst_n` is released and while no supply is up, `por_n_o` is 0, `io_hiz_o` is 1 and `cfg_start_o` is 0. `io_hiz_o` is always the inverse of `por_n_o`.
- R3: The ramp measurement starts when the first synchronized supply flag is high. `por_n_o` stays 0 for as long as any supply is still below trip.
- R4: Consider the cycle in which the last synchronized supply flag goes high while ramping. After it, the block spends exactly the selected delay in cycles before `por_n_o` goes to 1. Counted from the driving of the last pin, `por_n_o` is first 1 after 3 + delay rising edges.
- R5: `fast_sel_i` = 1 selects FAST_DLY and 0 selects STD_DLY. The value is captured in the cycle the last supply is seen high.
- R6: If the supplies are not all high within RAMP_MAX cycles of the ramp start, the block enters a failure state. In that state `por_n_o` stays 0 and `io_hiz_o` stays 1, even after all supplies come up.
- R7: The failure state is left only when every synchronized supply flag is low. Partial dropouts keep it. After leaving, a fresh power-up releases reset normally.
- R8: While running, a supply falling below trip drives `por_n_o` to 0 in the same cycle the synchronized flag falls, which is 2 edges after the pin.
- R9: At the end of the delay, release waits until every level-shifter flag is high. It then happens 3 edges after the last such pin rises.
- R10: `cfg_start_o` is a single-cycle pulse, high exactly in the first cycle `por_n_o` is 1.
- R11: The ramp timer is cleared only while all supplies are low. A partial dropout resumes the timer from its held value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer itself |
| sup_ok_i | input | N_SUP | Per-supply above-trip flags, asynchronous |
| lvl_ok_i | input | N_LVL | I/O level-shifter check pass flags, asynchronous |
| fast_sel_i | input | 1 | 1 selects fast delay, 0 standard delay |
| por_n_o | output | 1 | Master reset, active low (0 = device held in reset) |
| io_hiz_o | output | 1 | 1 = I/O pins and programming registers tri-stated |
| cfg_start_o | output | 1 | One-cycle strobe: configuration may begin |

## Verification
The supplies are brought up in several patterns: one at a time with gaps, all at once, and too slowly for the watchdog. The staggered bring-up fixes the release latency behind the last supply. The simultaneous bring-up adds the extra off-to-ramping cycle. The slow bring-up separates a timer that counts from the first supply from one that counts from the last. Dropouts are applied both partially and fully, in the running, delay and failure states. These show that only a full power-down clears the failure state and restarts the timer. A held-low level-shifter flag shows that release waits for it rather than for the delay alone.

// File: rtl/por_pkg.sv
package por_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_RAMP  = 3'd1,
    ST_DELAY = 3'd2,
    ST_RUN   = 3'd3,
    ST_FAIL  = 3'd4
  } por_state_t;
endpackage

// File: rtl/por_sync.sv
module por_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      logic meta_q, stab_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q <= 1'b0;
          stab_q <= 1'b0;
        end else begin
          meta_q <= d_i[g];
          stab_q <= meta_q;
        end
      end
      assign q_o[g] = stab_q;
    end
  endgenerate
endmodule

// File: rtl/por_counter.sv
module por_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= '0;
    else if (clr_i) q_o <= '0;
    else if (en_i)  q_o <= q_o + 1'b1;
  end
endmodule

// File: rtl/por_seq.sv
module por_seq
  import por_pkg::*;
#(
  parameter int N_SUP    = 4,
  parameter int N_LVL    = 2,
  parameter int RAMP_MAX = 500000,
  parameter int FAST_DLY = 200000,
  parameter int STD_DLY  = 5000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SUP-1:0] sup_ok_i,
  input  logic [N_LVL-1:0] lvl_ok_i,
  input  logic             fast_sel_i,
  output logic             por_n_o,
  output logic             io_hiz_o,
  output logic             cfg_start_o
);
  localparam int NSYN  = N_SUP + N_LVL;
  localparam int MAXV0 = (RAMP_MAX > FAST_DLY) ? RAMP_MAX : FAST_DLY;
  localparam int MAXV  = (MAXV0 > STD_DLY) ? MAXV0 : STD_DLY;
  localparam int CW    = $clog2(MAXV + 1);
  localparam logic [CW-1:0] RAMP_LAST = CW'(RAMP_MAX - 1);
  localparam logic [CW-1:0] FAST_LAST = CW'(FAST_DLY - 1);
  localparam logic [CW-1:0] STD_LAST  = CW'(STD_DLY - 1);

  logic [NSYN-1:0]  syn;
  logic [N_SUP-1:0] sup_s;
  logic [N_LVL-1:0] lvl_s;
  logic             sup_all, sup_none, lvl_all;
  por_state_t       st_q, st_d;
  logic             cfg_d, cfg_q, fast_q;
  logic [CW-1:0]    rt_q, dc_q, dly_last;
  logic             rt_clr, rt_en, dc_clr, dc_en;

  // two-flop synchronizers for every detector flag
  por_sync #(.W(NSYN)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({lvl_ok_i, sup_ok_i}),
    .q_o  (syn)
  );

  assign sup_s    = syn[N_SUP-1:0];
  assign lvl_s    = syn[N_SUP +: N_LVL];
  assign sup_all  = &sup_s;
  assign sup_none = ~|sup_s;
  assign lvl_all  = &lvl_s;

  // ramp window timer: cleared only while fully powered down
  assign rt_clr = (st_q == ST_OFF);
  assign rt_en  = (st_q == ST_RAMP) && !sup_all && !sup_none && (rt_q != RAMP_LAST);

  por_counter #(.W(CW)) u_ramp_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr_i(rt_clr),
    .en_i (rt_en),
    .q_o  (rt_q)
  );

  // post-trip delay counter
  assign dly_last = fast_q ? FAST_LAST : STD_LAST;
  assign dc_clr   = (st_q != ST_DELAY);
  assign dc_en    = (st_q == ST_DELAY) && sup_all && (dc_q != dly_last);

  por_counter #(.W(CW)) u_dly_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr_i(dc_clr),
    .en_i (dc_en),
    .q_o  (dc_q)
  );

  always_comb begin
    st_d  = st_q;
    cfg_d = 1'b0;
    unique case (st_q)
      ST_OFF:   if (!sup_none) st_d = ST_RAMP;
      ST_RAMP: begin
        if (sup_all)                st_d = ST_DELAY;
        else if (sup_none)          st_d = ST_OFF;
        else if (rt_q == RAMP_LAST) st_d = ST_FAIL;
      end
      ST_DELAY: begin
        if (!sup_all) st_d = sup_none ? ST_OFF : ST_RAMP;
        else if ((dc_q == dly_last) && lvl_all) begin
          st_d  = ST_RUN;
          cfg_d = 1'b1;
        end
      end
      ST_RUN:   if (!sup_all) st_d = sup_none ? ST_OFF : ST_RAMP;
      ST_FAIL:  if (sup_none) st_d = ST_OFF;
      default:  st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      cfg_q  <= 1'b0;
      fast_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      cfg_q <= cfg_d;
      if ((st_q == ST_RAMP) && sup_all) fast_q <= fast_sel_i;
    end
  end

  // reset drops in the very cycle a synchronized dropout appears
  assign por_n_o     = (st_q == ST_RUN) && sup_all;
  assign io_hiz_o    = ~por_n_o;
  assign cfg_start_o = cfg_q;

  a_r11_ramp_timer_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    rt_q <= RAMP_LAST);
  a_r6_fail_holds_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FAIL) |-> (io_hiz_o && !por_n_o));
  a_r7_fail_needs_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_FAIL) && !sup_none) |=> (st_q == ST_FAIL));
  a_r8_dropout_leaves_run: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_RUN) && !sup_all) |=> (st_q != ST_RUN));
  a_r10_cfg_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_start_o |=> !cfg_start_o);
  a_r10_cfg_with_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(por_n_o) |-> cfg_start_o);
  a_r9_release_needs_lvl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(por_n_o) |-> $past(lvl_all));
  a_r4_release_after_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(por_n_o) |-> ($past(dc_q) == $past(dly_last)));
endmodule

// File: tb/por_seq_tb.sv
module por_seq_tb;
  localparam int NS   = 4;
  localparam int NL   = 2;
  localparam int RMAX = 40;
  localparam int FD   = 8;
  localparam int SD   = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] sup = '0;
  logic [NL-1:0] lvl = '1;
  logic          fast = 1'b1;
  logic          por_n, io_hiz, cfg;

  int checks = 0;
  int errors = 0;
  string cur_req = "R2";

  always #10 clk = ~clk;

  por_seq #(.N_SUP(NS), .N_LVL(NL), .RAMP_MAX(RMAX), .FAST_DLY(FD), .STD_DLY(SD)) u_dut (
    .clk(clk), .rst_n(rst_n), .sup_ok_i(sup), .lvl_ok_i(lvl), .fast_sel_i(fast),
    .por_n_o(por_n), .io_hiz_o(io_hiz), .cfg_start_o(cfg)
  );

  // behavioural reference: 0 off, 1 ramp, 2 delay, 3 run, 4 fail
  int            m_st, m_rt, m_dc, m_dly;
  logic [NS-1:0] m_s1, m_s2;
  logic [NL-1:0] m_l1, m_l2;
  logic          m_cfg;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_rt = 0; m_dc = 0; m_dly = FD; m_cfg = 0;
      m_s1 = '0; m_s2 = '0; m_l1 = '0; m_l2 = '0;
    end else begin
      bit all_up, none_up, lv;
      all_up = (m_s2 == '1); none_up = (m_s2 == '0); lv = (m_l2 == '1);
      m_cfg = 0;
      case (m_st)
        0: begin m_rt = 0; if (!none_up) m_st = 1; end
        1: begin
          if (all_up) begin m_st = 2; m_dc = 0; m_dly = fast ? FD : SD; end
          else if (none_up) m_st = 0;
          else if (m_rt == RMAX - 1) m_st = 4;
          else m_rt++;
        end
        2: begin
          if (!all_up) m_st = none_up ? 0 : 1;
          else if (m_dc == m_dly - 1) begin
            if (lv) begin m_st = 3; m_cfg = 1; end
          end else m_dc++;
        end
        3: if (!all_up) m_st = none_up ? 0 : 1;
        default: if (none_up) m_st = 0;
      endcase
      if (m_st != 2) m_dc = 0;
      m_s2 = m_s1; m_s1 = sup; m_l2 = m_l1; m_l1 = lvl;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic e_por;
      e_por = (m_st == 3) && (m_s2 == '1);
      checks++;
      if (por_n !== e_por || io_hiz !== !e_por || cfg !== m_cfg) begin
        errors++;
        $display("FAIL %s model: por_n=%b io_hiz=%b cfg=%b expected %b %b %b",
                 cur_req, por_n, io_hiz, cfg, e_por, !e_por, m_cfg);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(input int exp, input string tag);
    int n = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      n++;
      if (por_n) break;
    end
    chk(n == exp, tag, n, exp);
    chk(cfg == 1'b1, "R10 strobe at release", int'(cfg), 1);
    @(negedge clk);
    chk(cfg == 1'b0, "R10 strobe one cycle", int'(cfg), 0);
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    chk(por_n == 0, "R2 reset por_n", int'(por_n), 0);
    chk(io_hiz == 1, "R2 reset io_hiz", int'(io_hiz), 1);
    chk(cfg == 0, "R2 reset cfg", int'(cfg), 0);

    // staggered bring-up, fast delay
    cur_req = "R3";
    sup[0] = 1'b1; cyc(5);
    chk(por_n == 0, "R3 held during ramp", int'(por_n), 0);
    sup[1] = 1'b1; cyc(5);
    sup[2] = 1'b1; cyc(3);
    cur_req = "R4";
    sup[3] = 1'b1;
    measure(3 + FD, "R4 release latency fast");

    // partial dropout while running
    cur_req = "R8";
    cyc(4);
    sup[2] = 1'b0;
    @(negedge clk);
    chk(por_n == 1, "R1 two-flop latency", int'(por_n), 1);
    @(negedge clk);
    chk(por_n == 0, "R8 dropout reasserts", int'(por_n), 0);
    cur_req = "R11";
    cyc(3);
    sup[2] = 1'b1;
    measure(3 + FD, "R11 resume after partial drop");

    // simultaneous bring-up, standard delay
    cur_req = "R5";
    sup = '0; cyc(6);
    fast = 1'b0;
    sup = '1;
    measure(4 + SD, "R5 standard delay");
    fast = 1'b1;

    // level-shifter gating
    cur_req = "R9";
    sup = '0; cyc(6);
    lvl = 2'b01;
    sup = '1; cyc(40);
    chk(por_n == 0, "R9 waits for level shifters", int'(por_n), 0);
    lvl = 2'b11;
    measure(3, "R9 release after level check");

    // ramp timeout
    cur_req = "R6";
    sup = '0; cyc(6);
    sup = 4'b0001; cyc(50);
    sup = '1; cyc(30);
    chk(por_n == 0, "R6 fail holds reset", int'(por_n), 0);
    chk(io_hiz == 1, "R6 fail keeps tri-state", int'(io_hiz), 1);
    cur_req = "R7";
    sup = 4'b1110; cyc(10);
    sup = '1; cyc(30);
    chk(por_n == 0, "R7 partial drop keeps fail", int'(por_n), 0);
    sup = '0; cyc(6);
    sup = '1;
    measure(4 + FD, "R7 recovery after full drop");

    // timer restart on full power-down
    cur_req = "R11";
    sup = '0; cyc(6);
    sup = 4'b0001; cyc(30);
    sup = '0; cyc(6);
    sup = 4'b0001; cyc(30);
    sup = '1;
    measure(3 + FD, "R11 timer restarted");

    cyc(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule